// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block turns level-sensitive PCI interrupt pins into interrupt-controller inputs. A device is identified by its slot number and its pin (INTA to INTD). A per-slot table folds every such pin onto one of eight shared lines. A lookup port answers that query combinationally, so the fabric can find the shared line that carries a given device pin.

The levels of the eight shared lines come in on `pirq_in`. Each line drives two destinations at once. The first is a fixed APIC input: line n always drives output 16+n. The second is one of sixteen legacy PIC inputs, chosen through a programmable routing byte that can also disable the PIC path. A power-management SCI level is also merged in. A select field steers it onto one of five outputs, or onto none. All outputs are combinational from `pirq_in`, `sci_in` and the registered configuration.

The configuration is written and read through a small register bus with a 4-bit address. A write is captured on a rising clock edge. A read is combinational. Addresses 0 to 7 hold the routing bytes for lines 0 to 7. Addresses 8 to 14 hold the mapping words for slots 25 to 31. Address 15 holds the SCI select.

Top module: `pirq_router`

## Requirements
- R1: Address n (0 to 7) is the routing byte of shared line n. Bit 7 set disables the PIC route, and bits 4:0 give the PIC input number. Bits 6:5 and 15:8 read as zero. Every routing byte resets to 0x80.
- R2: While the SCI is not contributing, PIC output i (0 to 15) is high exactly when some line n has `pirq_in[n]` high, its route enabled, and its input number equal to i.
- R3: A line whose enabled route names an input number from 16 to 31 drives no PIC output.
- R4: APIC output 16+n equals `pirq_in[n]` whenever `sci_in` is low, whatever routing byte line n has.
- R5: Address 15 bits 2:0 select the SCI destination. The code values are 0 for input 9, 1 for 10, 2 for 11, 3 for 20 and 4 for 21. Codes 5 to 7 send the SCI nowhere. The field resets to 0, and the other bits read as zero.
- R6: `sci_in` is ORed into the output named by the select, together with whatever that output already carries.
- R7: If the select is rewritten while `sci_in` is high, then from the cycle after the write edge the old output drops and the new output rises, in the same cycle.
- R8: For any slot below 25, and for any writable slot before it is first written, pin p of slot s maps to line ((s+p) mod 4)+4.
- R9: Slot 30 always maps INTA to INTD onto lines 4 to 7. Its mapping word (address 13) ignores writes and reads as zero.
- R10: Address 8+(s-25) holds the 16-bit mapping word of slot s, for s from 25 to 31 other than 30. It reads back as written. For pin p, bits 4p+2:4p select the line, and bit 4p+3 has no effect on the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| slot_sel | input | 5 | Slot number of the mapping lookup |
| pin_sel | input | 2 | Pin (0 = INTA to 3 = INTD) of the mapping lookup |
| line_sel | output | 3 | Shared line that carries the looked-up pin |
| pirq_in | input | 8 | Levels of the shared lines |
| sci_in | input | 1 | SCI level |
| gsi_out | output | 24 | Outputs 0 to 15 go to the PIC, 16 to 23 go to the APIC |

## Verification
The bench builds the block with its default parameters. That gives eight shared lines, sixteen PIC inputs, and mapping slots 25 to 31 with slot 30 fixed. The 5-bit input field therefore covers both the PIC range and the 16 to 31 range that must drive nothing. A shadow model of all sixteen registers checks random write sequences, random line levels and random lookups across every slot and pin. Directed cases cover the following:
- the out-of-range route;
- writes to the fixed slot;
- the unused field bit;
- reserved SCI codes;
- moving the SCI while it is asserted.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

  localparam int unsigned IRQ_W   = 5;   // PIC input number field of a routing byte
  localparam int unsigned DIS_BIT = 7;   // route-disable flag position
  localparam int unsigned SEL_W   = 3;   // SCI select field width
  localparam int unsigned PINS    = 4;   // INTA..INTD
  localparam int unsigned FIELD_W = 4;   // per-pin field in a mapping word

  typedef struct packed {
    logic             valid;
    logic [IRQ_W-1:0] gsi;
  } sci_dest_t;

  function automatic sci_dest_t sci_decode(input logic [SEL_W-1:0] sel);
    sci_dest_t d;
    d.valid = 1'b1;
    case (sel)
      3'd0:    d.gsi = 5'd9;
      3'd1:    d.gsi = 5'd10;
      3'd2:    d.gsi = 5'd11;
      3'd3:    d.gsi = 5'd20;
      3'd4:    d.gsi = 5'd21;
      default: begin
        d.valid = 1'b0;
        d.gsi   = '0;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned MAP_SLOTS = 7,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  input  logic [DATA_W-1:0]               map_rdata,
  output logic [DATA_W-1:0]               reg_rdata,
  output logic                            map_we,
  output logic [IDX_W-1:0]                map_idx,
  output logic [NUM_LINES-1:0]            route_dis,
  output logic [NUM_LINES-1:0][IRQ_W-1:0] route_irq,
  output logic [SEL_W-1:0]                sci_sel
);

  localparam logic [ADDR_W-1:0] MAP_LO   = ADDR_W'(NUM_LINES);
  localparam logic [ADDR_W-1:0] SCI_ADDR = ADDR_W'(NUM_LINES + MAP_SLOTS);

  logic                            route_hit, map_hit, sci_hit;
  logic [NUM_LINES-1:0]            route_en;
  logic [NUM_LINES-1:0]            dis_q, dis_d;
  logic [NUM_LINES-1:0][IRQ_W-1:0] irq_q, irq_d;
  logic                            sel_en;
  logic [SEL_W-1:0]                sel_q, sel_d;

  assign route_hit = (reg_addr < MAP_LO);
  assign map_hit   = (reg_addr >= MAP_LO) && (reg_addr < SCI_ADDR);
  assign sci_hit   = (reg_addr == SCI_ADDR);
  assign map_we    = reg_we && map_hit;
  assign map_idx   = IDX_W'(reg_addr - MAP_LO);
  assign sel_en    = reg_we && sci_hit;
  assign sel_d     = reg_wdata[SEL_W-1:0];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_route
    assign route_en[l] = reg_we && (reg_addr == ADDR_W'(l));
    always_comb begin
      dis_d[l] = reg_wdata[DIS_BIT];
      irq_d[l] = reg_wdata[IRQ_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dis_q[l] <= 1'b1;
        irq_q[l] <= '0;
      end else if (route_en[l]) begin
        dis_q[l] <= dis_d[l];
        irq_q[l] <= irq_d[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (route_hit) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (reg_addr == ADDR_W'(l)) begin
          reg_rdata[DIS_BIT]     = dis_q[l];
          reg_rdata[IRQ_W-1:0]   = irq_q[l];
        end
      end
    end else if (map_hit) begin
      reg_rdata = map_rdata;
    end else if (sci_hit) begin
      reg_rdata[SEL_W-1:0] = sel_q;
    end
  end

  assign route_dis = dis_q;
  assign route_irq = irq_q;
  assign sci_sel   = sel_q;

endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned BASE_SLOT = 25,
  parameter int unsigned HARD_SLOT = 30,
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DATA_W-1:0]             rd_data,
  input  logic [$clog2(NUM_SLOTS)-1:0]  slot_sel,
  input  logic [1:0]                    pin_sel,
  output logic [$clog2(NUM_LINES)-1:0]  line_sel
);

  localparam int unsigned MAP_SLOTS = NUM_SLOTS - BASE_SLOT;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned LINE_W    = $clog2(NUM_LINES);
  localparam int unsigned HALF      = NUM_LINES / 2;

  function automatic logic [DATA_W-1:0] reset_word(input int unsigned slot);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int unsigned p = 0; p < PINS; p++)
      w[p*FIELD_W +: FIELD_W] = FIELD_W'(((slot + p) % HALF) + HALF);
    return w;
  endfunction

  logic [DATA_W-1:0] words [MAP_SLOTS];

  for (genvar i = 0; i < MAP_SLOTS; i++) begin : g_slot
    if (BASE_SLOT + i == HARD_SLOT) begin : g_hard
      assign words[i] = '0;
    end else begin : g_soft
      logic              en;
      logic [DATA_W-1:0] w_q, w_d;
      assign en  = wr_en && (idx == IDX_W'(i));
      assign w_d = wr_data;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  w_q <= reset_word(BASE_SLOT + i);
        else if (en) w_q <= w_d;
      end
      assign words[i] = w_q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < MAP_SLOTS; i++)
      if (idx == IDX_W'(i)) rd_data = words[i];
  end

  always_comb begin
    logic [DATA_W-1:0] w;
    w        = '0;
    line_sel = LINE_W'(((int'(slot_sel) + int'(pin_sel)) % HALF) + HALF);
    if (slot_sel == SLOT_W'(HARD_SLOT)) begin
      line_sel = LINE_W'(HALF + int'(pin_sel));
    end else if (slot_sel >= SLOT_W'(BASE_SLOT)) begin
      for (int i = 0; i < MAP_SLOTS; i++)
        if (slot_sel == SLOT_W'(BASE_SLOT + i)) w = words[i];
      line_sel = w[pin_sel*FIELD_W +: LINE_W];
    end
  end

endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 8,
  parameter int unsigned PIC_INPUTS = 16
) (
  input  logic [NUM_LINES-1:0]              pirq_in,
  input  logic [NUM_LINES-1:0]              route_dis,
  input  logic [NUM_LINES-1:0][IRQ_W-1:0]   route_irq,
  input  logic                              sci_in,
  input  logic [SEL_W-1:0]                  sci_sel,
  output logic [PIC_INPUTS+NUM_LINES-1:0]   gsi_out
);

  localparam int unsigned NUM_GSI = PIC_INPUTS + NUM_LINES;

  sci_dest_t sci_dest;
  assign sci_dest = sci_decode(sci_sel);

  always_comb begin
    gsi_out = '0;
    for (int i = 0; i < PIC_INPUTS; i++)
      for (int n = 0; n < NUM_LINES; n++)
        if (pirq_in[n] && !route_dis[n] && (route_irq[n] == IRQ_W'(i)))
          gsi_out[i] = 1'b1;
    for (int n = 0; n < NUM_LINES; n++)
      if (pirq_in[n]) gsi_out[PIC_INPUTS+n] = 1'b1;
    for (int g = 0; g < NUM_GSI; g++)
      if (sci_in && sci_dest.valid && (sci_dest.gsi == IRQ_W'(g)))
        gsi_out[g] = 1'b1;
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 8,
  parameter int unsigned PIC_INPUTS = 16,
  parameter int unsigned NUM_SLOTS  = 32,
  parameter int unsigned BASE_SLOT  = 25,
  parameter int unsigned HARD_SLOT  = 30,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_we,
  input  logic [ADDR_W-1:0]                   reg_addr,
  input  logic [DATA_W-1:0]                   reg_wdata,
  output logic [DATA_W-1:0]                   reg_rdata,
  input  logic [$clog2(NUM_SLOTS)-1:0]        slot_sel,
  input  logic [1:0]                          pin_sel,
  output logic [$clog2(NUM_LINES)-1:0]        line_sel,
  input  logic [NUM_LINES-1:0]                pirq_in,
  input  logic                                sci_in,
  output logic [PIC_INPUTS+NUM_LINES-1:0]     gsi_out
);

  localparam int unsigned MAP_SLOTS = NUM_SLOTS - BASE_SLOT;
  localparam int unsigned IDX_W     = $clog2(MAP_SLOTS);

  logic [1:0]                      rst_pipe;
  logic                            rst_int_n;
  logic                            map_we;
  logic [IDX_W-1:0]                map_idx;
  logic [DATA_W-1:0]               map_rdata;
  logic [NUM_LINES-1:0]            route_dis;
  logic [NUM_LINES-1:0][IRQ_W-1:0] route_irq;
  logic [SEL_W-1:0]                sci_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pirq_cfg_regs #(
    .NUM_LINES(NUM_LINES), .MAP_SLOTS(MAP_SLOTS), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .map_rdata(map_rdata), .reg_rdata(reg_rdata),
    .map_we(map_we), .map_idx(map_idx), .route_dis(route_dis),
    .route_irq(route_irq), .sci_sel(sci_sel)
  );

  pirq_slot_map #(
    .NUM_SLOTS(NUM_SLOTS), .BASE_SLOT(BASE_SLOT), .HARD_SLOT(HARD_SLOT),
    .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_map (
    .clk(clk), .rst_n(rst_int_n), .wr_en(map_we), .idx(map_idx),
    .wr_data(reg_wdata), .rd_data(map_rdata), .slot_sel(slot_sel),
    .pin_sel(pin_sel), .line_sel(line_sel)
  );

  pirq_irq_merge #(
    .NUM_LINES(NUM_LINES), .PIC_INPUTS(PIC_INPUTS)
  ) u_merge (
    .pirq_in(pirq_in), .route_dis(route_dis), .route_irq(route_irq),
    .sci_in(sci_in), .sci_sel(sci_sel), .gsi_out(gsi_out)
  );

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 8,
  parameter int unsigned PIC_INPUTS = 16,
  parameter int unsigned NUM_SLOTS  = 32,
  parameter int unsigned BASE_SLOT  = 25,
  parameter int unsigned HARD_SLOT  = 30,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 16
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [ADDR_W-1:0]                  reg_addr,
  input logic [DATA_W-1:0]                  reg_rdata,
  input logic [$clog2(NUM_SLOTS)-1:0]       slot_sel,
  input logic [1:0]                         pin_sel,
  input logic [$clog2(NUM_LINES)-1:0]       line_sel,
  input logic [NUM_LINES-1:0]               pirq_in,
  input logic                               sci_in,
  input logic [SEL_W-1:0]                   sci_sel,
  input logic [PIC_INPUTS+NUM_LINES-1:0]    gsi_out
);

  localparam int unsigned SLOT_W  = $clog2(NUM_SLOTS);
  localparam int unsigned LINE_W  = $clog2(NUM_LINES);
  localparam int unsigned HALF    = NUM_LINES / 2;
  localparam int unsigned NUM_GSI = PIC_INPUTS + NUM_LINES;
  localparam logic [ADDR_W-1:0] HARD_ADDR = ADDR_W'(NUM_LINES + HARD_SLOT - BASE_SLOT);

  logic sci_sel_ok;
  assign sci_sel_ok = (sci_sel < SEL_W'(5));

  a_r4_apic_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !sci_in |-> gsi_out[NUM_GSI-1:PIC_INPUTS] == pirq_in);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_in == '0 && !sci_in) |-> gsi_out == '0);

  a_r9_hard_slot_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    slot_sel == SLOT_W'(HARD_SLOT) |-> line_sel == LINE_W'(HALF + int'(pin_sel)));

  a_r9_hard_slot_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == HARD_ADDR |-> reg_rdata == '0);

  a_r8_low_slot_default: assert property (@(posedge clk) disable iff (!rst_n)
    slot_sel < SLOT_W'(BASE_SLOT)
      |-> line_sel == LINE_W'(((int'(slot_sel) + int'(pin_sel)) % HALF) + HALF));

  a_r6_sci_single_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_in == '0 && sci_in) |-> $countones(gsi_out) == (sci_sel_ok ? 1 : 0));

  a_r7_sci_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_in && $past(sci_in) && pirq_in == '0 && $past(pirq_in) == '0 &&
     sci_sel_ok && $past(sci_sel_ok) && sci_sel != $past(sci_sel))
      |-> (gsi_out != $past(gsi_out) && $countones(gsi_out) == 1));

endmodule

bind pirq_router pirq_router_chk #(
  .NUM_LINES(NUM_LINES), .PIC_INPUTS(PIC_INPUTS), .NUM_SLOTS(NUM_SLOTS),
  .BASE_SLOT(BASE_SLOT), .HARD_SLOT(HARD_SLOT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .slot_sel(slot_sel), .pin_sel(pin_sel), .line_sel(line_sel),
  .pirq_in(pirq_in), .sci_in(sci_in), .sci_sel(sci_sel), .gsi_out(gsi_out)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [4:0]  slot_sel = '0;
  logic [1:0]  pin_sel = '0;
  logic [2:0]  line_sel;
  logic [7:0]  pirq_in = '0;
  logic        sci_in = 1'b0;
  logic [23:0] gsi_out;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_route [8];
  logic [15:0] m_map   [7];
  logic [2:0]  m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_sel(slot_sel),
    .pin_sel(pin_sel), .line_sel(line_sel), .pirq_in(pirq_in),
    .sci_in(sci_in), .gsi_out(gsi_out)
  );

  function automatic logic [15:0] rst_word(int s);
    logic [15:0] w = '0;
    for (int p = 0; p < 4; p++) w[p*4 +: 4] = 4'(((s + p) % 4) + 4);
    return w;
  endfunction

  function automatic logic [15:0] exp_read(int a);
    if (a < 8)  return {8'h00, m_route[a]};
    if (a < 15) return (a == 13) ? 16'h0000 : m_map[a-8];
    return {13'd0, m_sel};
  endfunction

  function automatic logic [2:0] exp_line(int s, int p);
    if (s == 30) return 3'(4 + p);
    if (s >= 25) return m_map[s-25][p*4 +: 3];
    return 3'(((s + p) % 4) + 4);
  endfunction

  function automatic int sci_target(logic [2:0] sel);
    case (sel)
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd3: return 20;
      3'd4: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [23:0] exp_gsi(logic [7:0] pq, logic sc);
    logic [23:0] g = '0;
    for (int n = 0; n < 8; n++) begin
      if (pq[n]) g[16+n] = 1'b1;
      if (pq[n] && !m_route[n][7] && m_route[n][4:0] < 5'd16) g[m_route[n][3:0]] = 1'b1;
    end
    if (sc && sci_target(m_sel) >= 0) g[sci_target(m_sel)] = 1'b1;
    return g;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 8) m_route[a] = {d[7], 2'b00, d[4:0]};
    else if (a < 15) begin if (a != 13) m_map[a-8] = d; end
    else m_sel = d[2:0];
  endtask

  task automatic rd_chk(input string req, input int a);
    reg_addr = 4'(a); #1;
    chk(req, 32'(reg_rdata), 32'(exp_read(a)));
  endtask

  task automatic gsi_chk(input string req, input logic [7:0] pq, input logic sc);
    pirq_in = pq; sci_in = sc; #1;
    chk(req, 32'(gsi_out), 32'(exp_gsi(pq, sc)));
  endtask

  task automatic map_chk(input string req, input int s, input int p);
    slot_sel = 5'(s); pin_sel = 2'(p); #1;
    chk(req, 32'(line_sel), 32'(exp_line(s, p)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m_route[i] = 8'h80;
    for (int i = 0; i < 7; i++) m_map[i] = (i == 5) ? 16'h0 : rst_word(25 + i);
    m_sel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state: R1 routing bytes, R5 select, R10 mapping words, R8 lookups
    for (int a = 0; a < 16; a++) rd_chk(a < 8 ? "R1" : (a < 15 ? "R10" : "R5"), a);
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) map_chk("R8", s, p);
    gsi_chk("R4", 8'hA5, 1'b0);

    // R2: two lines sharing a PIC input, one disabled line
    wr(0, 16'h0005); wr(1, 16'h0005); wr(2, 16'h0085);
    gsi_chk("R2", 8'h01, 1'b0);
    gsi_chk("R2", 8'h02, 1'b0);
    gsi_chk("R2", 8'h04, 1'b0);
    // R3: enabled route to input 16 and 31
    wr(3, 16'h0010); wr(4, 16'h001F);
    gsi_chk("R3", 8'h18, 1'b0);

    // R9: fixed slot ignores writes
    wr(13, 16'hFFFF);
    rd_chk("R9", 13);
    for (int p = 0; p < 4; p++) map_chk("R9", 30, p);
    // R10: field bit 3 unused, word reads back
    wr(8, 16'hF8A9);
    rd_chk("R10", 8);
    map_chk("R10", 25, 0); map_chk("R10", 25, 1);
    map_chk("R10", 25, 2); map_chk("R10", 25, 3);

    // R5/R6: SCI onto a line already in use, reserved codes
    wr(15, 16'hFFF8 | 16'h0);
    rd_chk("R5", 15);
    gsi_chk("R6", 8'h00, 1'b1);
    wr(15, 16'h0005);
    gsi_chk("R5", 8'h00, 1'b1);
    wr(15, 16'h0007);
    gsi_chk("R5", 8'h01, 1'b1);
    wr(15, 16'h0003);
    gsi_chk("R6", 8'h10, 1'b1);

    // R7: move SCI while it is high
    wr(15, 16'h0001);
    gsi_chk("R7", 8'h00, 1'b1);
    pirq_in = 8'h00; sci_in = 1'b1;
    wr(15, 16'h0004);
    #1;
    chk("R7", 32'(gsi_out), 32'(24'h1 << 21));
    wr(15, 16'h0002);
    #1;
    chk("R7", 32'(gsi_out), 32'(24'h1 << 11));

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [15:0] d;
      int a;
      a = int'($urandom_range(0, 15));
      d = 16'($urandom);
      if (a < 8 && $urandom_range(0, 1) == 0) d[4] = 1'b0;
      wr(a, d);
      rd_chk(a < 8 ? "R1" : (a < 15 ? (a == 13 ? "R9" : "R10") : "R5"), int'($urandom_range(0, 15)));
      gsi_chk("R2", 8'($urandom), 1'($urandom));
      map_chk("R10", int'($urandom_range(0, 31)), int'($urandom_range(0, 3)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule